// File: doc/BRIEF.md
# Resettable Preinitialized RAM

This block is a small synchronous memory that comes out of every reset holding its power-up image, without stepping through its addresses to rewrite them. A constant image, fixed by a parameter, acts as a read-only backing store. A writable array takes every update made during operation. A vector of per-location "dirty" flags records which locations have been written since the last reset.

On a read, the flag for the addressed location chooses the word. A clear flag returns the image word and a set flag returns the stored word. Reset clears every flag in one cycle, so all earlier writes vanish at the same time, and the cost of a reset is the same for any depth. The writable array is never preloaded and is never reset.

The block has one write port and one read port. The read has a latency of one cycle. When a read and a write hit the same location in the same cycle, the read sees the old contents. The depth, the word width and the image are all parameters. The default is ten 10-bit signed words holding 0 through 9.

Top module: `image_ram`

## Requirements
- R1: In the first reads after a reset, every address `a` below DEPTH returns image word `a`. In the default configuration that value is `a`.
- R2: A write to an in-range address, followed by a read of that address, returns the written word. This holds as long as no reset falls between the two.
- R3: A read with `rd_en` high at a rising edge drives its word on `rd_data` right after that edge, and the word stays there until the next edge.
- R4: While `rd_en` is low and reset is low, `rd_data` keeps its previous value.
- R5: A read and a write to the same address in one cycle return the contents from before the write. For a location not yet written this is the image word, and for a written one it is the previously stored word. The new word is returned from the next read onwards.
- R6: A single reset cycle discards every earlier write, whatever the depth. During a reset cycle `rd_data` becomes 0 at that edge.
- R7: A write presented while reset is high has no effect. A later read of that address returns the image word.
- R8: A write to an address at or above DEPTH changes no location. A read of such an address returns 0.
- R9: A write changes only its own location. Other unwritten locations keep returning their image words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; restores the image view |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address (AW = clog2 of DEPTH) |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | WIDTH | Read data, one cycle after the strobe |

## Verification
The bench checks the following corner cases, each against a design that gets it wrong:

- **Read and write to one address in the same cycle, at a location never written.** A design that forwarded the new word, or set the flag before sampling it, would return the new word instead of the image value.
- **Reset after a full sweep of writes, and a write held during reset.** A design whose reset missed part of the flag vector would return stale stored words. So would a design that let writes through during reset.
- **A write to one location, then reads of its neighbours.** A design with a broken flag index would show its neighbours switching from the image to undefined storage.
- **Out-of-range addresses and idle read cycles.** A design without address guards would alias onto real locations. A design without the read strobe would let the output drift.

A long mixed run with resets scattered through it compares every read against a model. After each reset the run sweeps the whole image.

// File: rtl/image_ram.sv
module image_ram #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 10,
  parameter int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter logic [DEPTH*WIDTH-1:0] IMAGE = {
    10'sd9, 10'sd8, 10'sd7, 10'sd6, 10'sd5,
    10'sd4, 10'sd3, 10'sd2, 10'sd1, 10'sd0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  localparam logic [AW:0] LIMIT = DEPTH[AW:0];

  logic [WIDTH-1:0] rom [DEPTH];
  logic [WIDTH-1:0] ram [DEPTH];
  logic [DEPTH-1:0] dirty;

  logic             wr_ok, rd_ok;
  logic [AW-1:0]    wr_idx, rd_idx;
  logic             hit_q, sel_q;
  logic [WIDTH-1:0] ram_q, rom_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = IMAGE[g*WIDTH +: WIDTH];
  end

  assign wr_ok  = wr_en && !rst && ({1'b0, wr_addr} < LIMIT);
  assign rd_ok  = {1'b0, rd_addr} < LIMIT;
  assign wr_idx = wr_ok ? wr_addr : '0;
  assign rd_idx = rd_ok ? rd_addr : '0;

  always_ff @(posedge clk) begin
    if (rst)        dirty <= '0;
    else if (wr_ok) dirty[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) ram[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      sel_q <= 1'b0;
      ram_q <= '0;
      rom_q <= '0;
    end else if (rd_en) begin
      hit_q <= rd_ok;
      sel_q <= dirty[rd_idx];
      ram_q <= ram[rd_idx];
      rom_q <= rom[rd_idx];
    end
  end

  assign rd_data = !hit_q ? '0 : (sel_q ? ram_q : rom_q);
endmodule

// File: rtl/image_ram_chk.sv
module image_ram_chk #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 10,
  parameter int AW = 4,
  parameter logic [DEPTH*WIDTH-1:0] IMAGE = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data
);
  localparam logic [AW:0] LIMIT = DEPTH[AW:0];

  logic [WIDTH-1:0] img [DEPTH];
  for (genvar g = 0; g < DEPTH; g++) begin : g_img
    assign img[g] = IMAGE[g*WIDTH +: WIDTH];
  end

  logic rd_in, wr_in;
  assign rd_in = {1'b0, rd_addr} < LIMIT;
  assign wr_in = {1'b0, wr_addr} < LIMIT;

  AST_RESET_ZEROES: assert property (@(posedge clk) rst |=> rd_data == '0); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R4

  AST_IMAGE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_in && $past(rst)) |=> rd_data == img[$past(rd_addr)]); // R1

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_in) ##1 (rd_en && rd_addr == $past(wr_addr))
    |=> rd_data == $past(wr_data, 2)); // R2

  AST_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_in) |=> rd_data == '0); // R8
endmodule

bind image_ram image_ram_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .IMAGE(IMAGE)
) u_chk (.*);

// File: tb/test_image_ram.sv
`timescale 1ns/1ps
module test_image_ram;
  localparam int DEPTH = 10;
  localparam int WIDTH = 10;
  localparam int AW = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0, rd_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;

  int vectors = 0;
  int errors = 0;

  logic [WIDTH-1:0] m_img [DEPTH];
  logic [WIDTH-1:0] m_ram [DEPTH];
  logic             m_dirty [DEPTH];
  logic [WIDTH-1:0] m_exp = '0;

  always #2.5 clk = ~clk;

  image_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) i_image_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic step(input logic rs, input logic we, input int wa, input int wd,
                      input logic re, input int ra, input string tag);
    @(negedge clk);
    rst = rs; wr_en = we; wr_addr = AW'(wa); wr_data = WIDTH'(wd);
    rd_en = re; rd_addr = AW'(ra);
    if (rs) begin
      m_exp = '0;
      for (int i = 0; i < DEPTH; i++) m_dirty[i] = 1'b0;
    end else begin
      if (re) m_exp = (ra < DEPTH) ? (m_dirty[ra] ? m_ram[ra] : m_img[ra]) : '0;
      if (we && wa < DEPTH) begin
        m_ram[wa] = WIDTH'(wd);
        m_dirty[wa] = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    vectors++;
    if (rd_data !== m_exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, rd_data, m_exp);
    end
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 0, 1, a, tag);
  endtask

  task automatic t_reset_image();
    step(1, 0, 0, 0, 1, 3, "R6 reset zeroes rd_data");
    sweep("R1 image after reset");
  endtask

  task automatic t_write_read();
    step(0, 1, 4, 300, 0, 0, "R4 idle read");
    step(0, 0, 0, 0, 1, 4, "R2 write then read");
    step(0, 0, 0, 0, 1, 5, "R9 neighbour above keeps image");
    step(0, 0, 0, 0, 1, 3, "R9 neighbour below keeps image");
    step(0, 1, 7, -5, 1, 7, "R3 one cycle latency");
    step(0, 0, 0, 0, 0, 2, "R4 idle holds");
    step(0, 0, 0, 0, 0, 9, "R4 idle holds again");
  endtask

  task automatic t_read_first();
    step(1, 0, 0, 0, 0, 0, "R6 reset");
    step(0, 1, 6, 111, 1, 6, "R5 read-first from image");
    step(0, 1, 6, 222, 1, 6, "R5 read-first from ram");
    step(0, 0, 0, 0, 1, 6, "R5 new word next read");
  endtask

  task automatic t_reset_restore();
    for (int a = 0; a < DEPTH; a++) step(0, 1, a, 500 + a, 0, 0, "R4 fill");
    sweep("R2 filled contents");
    step(1, 1, 2, 77, 1, 2, "R7 write during reset");
    sweep("R6 R7 restored image");
  endtask

  task automatic t_out_of_range();
    step(0, 1, 12, 99, 1, 13, "R8 oor read zero");
    step(0, 1, 15, 98, 1, 15, "R8 oor read zero again");
    sweep("R8 oor write ignored");
  endtask

  task automatic t_random();
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 60) == 0) begin
        step(1, 1'($urandom), $urandom_range(0, 15), $urandom, 1, 0, "R6 random reset");
        sweep("R1 sweep after random reset");
      end else begin
        step(0, 1'($urandom), $urandom_range(0, 11), $urandom, 1'($urandom),
             $urandom_range(0, 11), "R2 R5 random traffic");
      end
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_img[i] = WIDTH'(i);
      m_dirty[i] = 1'b0;
    end
    t_reset_image();
    t_write_read();
    t_read_first();
    t_reset_restore();
    t_out_of_range();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R3: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule